// File: doc/BRIEF.md
# PWM Output Stage with Dead Time and Kill

This block turns the event pulses of a PWM counter into a complementary pair of drive lines. Overflow, underflow and compare-match pulses each carry a two-bit action that sets, clears, toggles or keeps an internal PWM line. That line is then split into a true output and a complementary output. In dead-time mode, each output that is about to switch on waits a programmable number of clock cycles. Each output that is switching off drops at once.

A kill input can blank both outputs in one of two ways. In level style, the outputs are blanked only while kill is high. In latched style, a rising edge of kill blanks them until the next terminal-count pulse. A third option leaves the outputs alone and instead sends a stop request to the counter on each rising edge of kill. A per-output polarity bit is applied after everything else, so it also sets the resting level of an output that is disabled or blanked. The counter is outside the block; it supplies the event pulses and the terminal-count pulse and consumes the stop request.

Top module: `pwm_outstage`

## Requirements
- R1: When `enable` is high, each event pulse applies its action code to the internal line at the next clock edge. The codes are 0 = set to 1, 1 = clear to 0, 2 = invert, 3 = no change. With no event pulse the line holds. With dead time off and both invert bits low, `out_true` equals the line and `out_compl` equals its inverse, in the cycle after the event.
- R2: When several events fire in the same cycle, their actions are applied in a fixed order: overflow first, then underflow, then compare match. Compare match therefore decides a conflict.
- R3: With `dt_en` high and `dt_len` = N > 0, a change of the line blanks both outputs for exactly N cycles, counted from the cycle in which the changed line is first visible. After that, the output matching the new line level turns on. Before polarity inversion, the two outputs are never high together.
- R4: If the line changes again while dead time is still running, both outputs stay off and the full N-cycle count starts again from the new change.
- R5: With `dt_en` low, or with `dt_len` = 0, the outputs follow the line with no blanking cycles.
- R6: In level kill (`kill_sync` = 0, `kill_stop` = 0), both outputs are at their idle level in every cycle in which `kill_in` is high. This takes effect in the same cycle, with no register in the path.
- R7: In latched kill (`kill_sync` = 1, `kill_stop` = 0), a rising edge of `kill_in` blanks both outputs from that same cycle onward. The outputs stay blanked until the cycle after a `tc_evt` pulse. A rising edge that arrives in the same cycle as `tc_evt` takes precedence, and the blanking continues.
- R8: With `kill_stop` = 1, `stop_req` is high for exactly the cycle of each rising edge of `kill_in` while `enable` is high. In this mode the outputs are not blanked, whatever `kill_sync` is set to.
- R9: Polarity inversion is the last step: `out_true` = drive XOR `inv_true` and `out_compl` = drive XOR `inv_compl`. A disabled or blanked output therefore rests at its invert bit.
- R10: While `enable` is low, event pulses are ignored. The line is cleared to 0 at the next edge, the kill latch and the dead-time count are cleared, and both outputs rest at their invert bits. After re-enable, `out_true` is at its inactive level and `out_compl` is active, with no dead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Counter enabled; low forces idle outputs |
| ovf_evt | input | 1 | Overflow event pulse |
| unf_evt | input | 1 | Underflow event pulse |
| cmp_evt | input | 1 | Compare-match event pulse |
| tc_evt | input | 1 | Terminal-count pulse |
| ovf_act | input | 2 | Action for overflow (0 set, 1 clear, 2 invert, 3 hold) |
| unf_act | input | 2 | Action for underflow |
| cmp_act | input | 2 | Action for compare match |
| kill_in | input | 1 | Kill trigger (level or rising edge) |
| kill_sync | input | 1 | 1 = latched kill until terminal count, 0 = level kill |
| kill_stop | input | 1 | 1 = kill requests a counter stop instead of blanking |
| dt_en | input | 1 | Dead-time insertion on |
| dt_len | input | DT_W | Dead time in clock cycles |
| inv_true | input | 1 | Polarity of the true output |
| inv_compl | input | 1 | Polarity of the complementary output |
| out_true | output | 1 | True PWM output |
| out_compl | output | 1 | Complementary PWM output |
| stop_req | output | 1 | One-cycle stop request to the counter |

## Verification
Two pairs of functions can land in the same cycle. One pair is a kill rising edge in latched mode together with a terminal-count pulse; the other is a compare-match pulse together with an overflow pulse. The bench drives each pair together in directed steps. In the first case it expects the blanking to continue (R7). In the second it expects the compare-match action to decide the line (R2). Random segments then mix the same coincidences with line toggles during dead time. Every cycle's outputs are judged against a bench model that tracks the cycles since the last line change and the latched kill state.

// File: rtl/pwm_outstage_pkg.sv
package pwm_outstage_pkg;
   typedef enum logic [1:0] {
      ACT_SET  = 2'd0,
      ACT_CLR  = 2'd1,
      ACT_INV  = 2'd2,
      ACT_KEEP = 2'd3
   } line_act_e;

   // Apply one event's action to the line when that event fired.
   function automatic logic apply_act(input logic cur, input logic fire, input logic [1:0] code);
      logic res;
      res = cur;
      if (fire) begin
         case (line_act_e'(code))
            ACT_SET:  res = 1'b1;
            ACT_CLR:  res = 1'b0;
            ACT_INV:  res = ~cur;
            default:  res = cur;
         endcase
      end
      return res;
   endfunction
endpackage

// File: rtl/pwm_os_line.sv
module pwm_os_line
   import pwm_outstage_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable,
   input  logic       ovf_evt,
   input  logic       unf_evt,
   input  logic       cmp_evt,
   input  logic [1:0] ovf_act,
   input  logic [1:0] unf_act,
   input  logic [1:0] cmp_act,
   output logic       line
);
   logic after_ovf, after_unf, line_nxt;

   // Fixed order: overflow, underflow, then compare match (R2)
   always_comb begin
      after_ovf = apply_act(line, ovf_evt, ovf_act);
      after_unf = apply_act(after_ovf, unf_evt, unf_act);
      line_nxt  = apply_act(after_unf, cmp_evt, cmp_act);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       line <= 1'b0;
      else if (!enable) line <= 1'b0;
      else              line <= line_nxt;
   end
endmodule

// File: rtl/pwm_os_dtime.sv
module pwm_os_dtime #(
   parameter int DT_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enable,
   input  logic            line,
   input  logic [DT_W-1:0] dt_len,
   output logic            on_true,
   output logic            on_compl
);
   logic            line_d;
   logic [DT_W-1:0] remain;
   logic            line_edge, hold_off;

   assign line_edge = line ^ line_d;
   assign hold_off  = (line_edge && (dt_len != '0)) || (remain != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_d <= 1'b0;
         remain <= '0;
      end else if (!enable) begin
         line_d <= 1'b0;
         remain <= '0;
      end else begin
         line_d <= line;
         if (line_edge)
            remain <= (dt_len == '0) ? '0 : dt_len - 1'b1;
         else if (remain != '0)
            remain <= remain - 1'b1;
      end
   end

   assign on_true  =  line && !hold_off;
   assign on_compl = !line && !hold_off;
endmodule

// File: rtl/pwm_os_kill.sv
module pwm_os_kill (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic kill_in,
   input  logic kill_sync,
   input  logic kill_stop,
   input  logic tc_evt,
   output logic blank,
   output logic stop_req
);
   logic kill_d, latched, rise;

   assign rise = kill_in && !kill_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kill_d  <= 1'b0;
         latched <= 1'b0;
      end else begin
         kill_d <= kill_in;
         if (!enable)                           latched <= 1'b0;
         else if (kill_sync && !kill_stop && rise) latched <= 1'b1;
         else if (tc_evt)                       latched <= 1'b0;
      end
   end

   always_comb begin
      if (kill_stop)      blank = 1'b0;
      else if (kill_sync) blank = latched || rise;
      else                blank = kill_in;
   end

   assign stop_req = enable && kill_stop && rise;
endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage #(
   parameter int DT_W   = 8,
   parameter bit HAS_DT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enable,
   input  logic            ovf_evt,
   input  logic            unf_evt,
   input  logic            cmp_evt,
   input  logic            tc_evt,
   input  logic [1:0]      ovf_act,
   input  logic [1:0]      unf_act,
   input  logic [1:0]      cmp_act,
   input  logic            kill_in,
   input  logic            kill_sync,
   input  logic            kill_stop,
   input  logic            dt_en,
   input  logic [DT_W-1:0] dt_len,
   input  logic            inv_true,
   input  logic            inv_compl,
   output logic            out_true,
   output logic            out_compl,
   output logic            stop_req
);
   localparam int DT_MAX = (1 << DT_W) - 1;

   if (DT_W < 1 || DT_W > 16) begin : g_bad_width
      $error("pwm_outstage: DT_W must lie in 1..16");
   end

   logic            line_q, on_t, on_c, kill_blank, drive_ok;
   logic [DT_W-1:0] dt_eff;

   assign dt_eff = dt_en ? dt_len : '0;

   pwm_os_line u_line (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .ovf_evt(ovf_evt), .unf_evt(unf_evt), .cmp_evt(cmp_evt),
      .ovf_act(ovf_act), .unf_act(unf_act), .cmp_act(cmp_act),
      .line(line_q)
   );

   if (HAS_DT) begin : g_dt
      pwm_os_dtime #(.DT_W(DT_W)) u_dt (
         .clk(clk), .rst_n(rst_n), .enable(enable), .line(line_q),
         .dt_len(dt_eff), .on_true(on_t), .on_compl(on_c)
      );
   end else begin : g_nodt
      logic unused_dt;
      assign unused_dt = ^{dt_eff, DT_MAX[0]};
      assign on_t = line_q;
      assign on_c = !line_q;
   end

   pwm_os_kill u_kill (
      .clk(clk), .rst_n(rst_n), .enable(enable), .kill_in(kill_in),
      .kill_sync(kill_sync), .kill_stop(kill_stop), .tc_evt(tc_evt),
      .blank(kill_blank), .stop_req(stop_req)
   );

   assign drive_ok  = enable && !kill_blank;
   // Polarity applied last: it also fixes the idle level (R9)
   assign out_true  = (drive_ok && on_t) ^ inv_true;
   assign out_compl = (drive_ok && on_c) ^ inv_compl;
endmodule

// File: rtl/pwm_outstage_chk.sv
module pwm_outstage_chk (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic ovf_evt,
   input logic unf_evt,
   input logic cmp_evt,
   input logic tc_evt,
   input logic kill_in,
   input logic kill_sync,
   input logic kill_stop,
   input logic inv_true,
   input logic inv_compl,
   input logic out_true,
   input logic out_compl,
   input logic stop_req,
   input logic line,
   input logic blank
);
   p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !ovf_evt && !unf_evt && !cmp_evt) |=> $stable(line));

   p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !((out_true ^ inv_true) && (out_compl ^ inv_compl)));

   p_level_kill_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!kill_sync && !kill_stop && kill_in) |->
         (out_true == inv_true && out_compl == inv_compl));

   p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && kill_sync && !kill_stop && blank && !tc_evt) |=>
         (blank || !kill_sync || kill_stop));

   p_stop_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |-> (kill_stop && kill_in && enable));

   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (out_true == inv_true && out_compl == inv_compl));

   p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !line);
endmodule

bind pwm_outstage pwm_outstage_chk u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .ovf_evt(ovf_evt),
   .unf_evt(unf_evt), .cmp_evt(cmp_evt), .tc_evt(tc_evt), .kill_in(kill_in),
   .kill_sync(kill_sync), .kill_stop(kill_stop), .inv_true(inv_true),
   .inv_compl(inv_compl), .out_true(out_true), .out_compl(out_compl),
   .stop_req(stop_req), .line(line_q), .blank(kill_blank)
);

// File: tb/sim_pwm_outstage.sv
module sim_pwm_outstage;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, ovf = 1'b0, unf = 1'b0, cmp = 1'b0, tc = 1'b0, kill = 1'b0;
   logic ksync = 1'b0, kstop = 1'b0, dten = 1'b0, invt = 1'b0, invc = 1'b0;
   logic [1:0] aovf = 2'd3, aunf = 2'd3, acmp = 2'd3;
   logic [7:0] dt = 8'd0;
   logic out_true, out_compl, stop_req;

   int errors = 0, checks = 0;
   bit done = 1'b0;

   // bench model state
   logic m_line = 1'b0, m_kl = 1'b0, m_kd = 1'b0;
   int   m_since = 1000;

   always #5 clk = ~clk;

   pwm_outstage u0 (
      .clk(clk), .rst_n(rst_n), .enable(en), .ovf_evt(ovf), .unf_evt(unf),
      .cmp_evt(cmp), .tc_evt(tc), .ovf_act(aovf), .unf_act(aunf), .cmp_act(acmp),
      .kill_in(kill), .kill_sync(ksync), .kill_stop(kstop), .dt_en(dten),
      .dt_len(dt), .inv_true(invt), .inv_compl(invc), .out_true(out_true),
      .out_compl(out_compl), .stop_req(stop_req)
   );

   function automatic logic act(input logic l, input logic f, input logic [1:0] c);
      if (!f) return l;
      case (c)
         2'd0: return 1'b1;
         2'd1: return 1'b0;
         2'd2: return ~l;
         default: return l;
      endcase
   endfunction

   function automatic logic [2:0] m_out();
      logic rise, blk, hold, t, c;
      int   dte;
      dte  = dten ? int'(dt) : 0;
      rise = kill && !m_kd;
      blk  = kstop ? 1'b0 : (ksync ? (m_kl || rise) : kill);
      hold = m_since < dte;
      t = en && !blk && !hold && m_line;
      c = en && !blk && !hold && !m_line;
      return {t ^ invt, c ^ invc, en && kstop && rise};
   endfunction

   task automatic m_step();
      logic rise, nl;
      rise = kill && !m_kd;
      if (!en) begin
         m_line = 1'b0; m_since = 1000; m_kl = 1'b0;
      end else begin
         nl = act(act(act(m_line, ovf, aovf), unf, aunf), cmp, acmp);
         if (nl != m_line) m_since = 0;
         else if (m_since < 1000) m_since++;
         m_line = nl;
         if (ksync && !kstop && rise) m_kl = 1'b1;
         else if (tc) m_kl = 1'b0;
      end
      m_kd = kill;
   endtask

   task automatic chk(input string tag, input logic [2:0] got, input logic [2:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual {true,compl,stop}=%b expected=%b at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic cyc(input string tag);
      logic [2:0] e;
      #1;
      e = m_out();
      chk(tag, {out_true, out_compl, stop_req}, e);
      @(posedge clk);
      m_step();
      @(negedge clk);
   endtask

   task automatic quiet();
      ovf = 0; unf = 0; cmp = 0; tc = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      en = 1'b1;
      #1;
      // reset state: line 0, no dead time pending
      chk("R10", {out_true, out_compl, stop_req}, 3'b010);
      cyc("R10");

      // R1: overflow sets the line
      ovf = 1; aovf = 2'd0; cyc("R1");
      quiet(); #1 chk("R1", {out_true, out_compl, stop_req}, 3'b100);
      cyc("R1");
      // R1: compare match inverts, underflow hold has no effect
      cmp = 1; acmp = 2'd2; unf = 1; aunf = 2'd3; cyc("R1");
      quiet(); #1 chk("R1", {out_true, out_compl, stop_req}, 3'b010);
      cyc("R1");
      // R2: overflow set and compare clear together -> compare wins
      ovf = 1; aovf = 2'd0; cmp = 1; acmp = 2'd1; cyc("R2");
      quiet(); #1 chk("R2", {out_true, out_compl, stop_req}, 3'b010);
      cyc("R2");

      // R3: dead time of 3 cycles on a rising line
      dten = 1; dt = 8'd3;
      ovf = 1; aovf = 2'd0; cyc("R3");
      quiet();
      for (int i = 0; i < 3; i++) begin
         #1 chk("R3", {out_true, out_compl, stop_req}, 3'b000);
         cyc("R3");
      end
      #1 chk("R3", {out_true, out_compl, stop_req}, 3'b100);
      // R4: toggle twice back to back, count restarts
      ovf = 1; aovf = 2'd2; cyc("R4");
      cyc("R4");
      quiet();
      for (int i = 0; i < 2; i++) begin
         #1 chk("R4", {out_true, out_compl, stop_req}, 3'b000);
         cyc("R4");
      end
      cyc("R4");
      #1 chk("R4", {out_true, out_compl, stop_req}, 3'b100);
      // R5: dead time length zero
      dt = 8'd0; cmp = 1; acmp = 2'd1; cyc("R5");
      quiet(); #1 chk("R5", {out_true, out_compl, stop_req}, 3'b010);
      cyc("R5");
      ovf = 1; aovf = 2'd0; cyc("R5"); quiet();
      // R6: level kill
      kill = 1; #1 chk("R6", {out_true, out_compl, stop_req}, 3'b000);
      cyc("R6"); kill = 0; cyc("R6");
      #1 chk("R6", {out_true, out_compl, stop_req}, 3'b100);
      // R7: latched kill with terminal count in the same cycle
      ksync = 1; kill = 1; tc = 1;
      #1 chk("R7", {out_true, out_compl, stop_req}, 3'b000);
      cyc("R7"); tc = 0; kill = 0;
      #1 chk("R7", {out_true, out_compl, stop_req}, 3'b000);
      cyc("R7"); tc = 1; cyc("R7"); tc = 0;
      #1 chk("R7", {out_true, out_compl, stop_req}, 3'b100);
      // R8: stop on kill, outputs untouched
      kstop = 1; kill = 1;
      #1 chk("R8", {out_true, out_compl, stop_req}, 3'b101);
      cyc("R8");
      #1 chk("R8", {out_true, out_compl, stop_req}, 3'b100);
      cyc("R8"); kill = 0; kstop = 0; ksync = 0; cyc("R8");
      // R9: inversion of active outputs
      invt = 1; invc = 1;
      #1 chk("R9", {out_true, out_compl, stop_req}, 3'b010);
      cyc("R9");
      // R10 / R9: disabled with events -> outputs rest at invert bits
      en = 0; ovf = 1; aovf = 2'd0;
      #1 chk("R9", {out_true, out_compl, stop_req}, 3'b110);
      cyc("R10"); cyc("R10");
      en = 1; quiet(); invt = 0; invc = 0;
      #1 chk("R10", {out_true, out_compl, stop_req}, 3'b010);
      cyc("R10");

      // random segments
      for (int s = 0; s < 24; s++) begin
         en = 0; quiet(); kill = 0; cyc("R10");
         dten = $urandom_range(0, 1); dt = 8'($urandom_range(0, 6));
         ksync = $urandom_range(0, 1); kstop = ($urandom_range(0, 3) == 0);
         invt = $urandom_range(0, 1); invc = $urandom_range(0, 1);
         en = 1;
         for (int k = 0; k < 250; k++) begin
            ovf = ($urandom_range(0, 7) == 0); unf = ($urandom_range(0, 7) == 0);
            cmp = ($urandom_range(0, 5) == 0); tc = ($urandom_range(0, 11) == 0);
            aovf = 2'($urandom_range(0, 3)); aunf = 2'($urandom_range(0, 3));
            acmp = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 15) == 0) kill = ~kill;
            if ($urandom_range(0, 99) == 0) en = ~en;
            cyc(kstop ? "R8" : (ksync ? "R7" : "R3"));
         end
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule